// File: doc/BRIEF.md
# Clock Control Register Bank with Enable Divider Chain

This block holds a bank of 32-bit configuration words behind a simple word-wide register port. From one of those words, the main control word, it derives a chain of single-cycle clock-enable pulses. The pulses are for CPU, bus and peripheral logic that runs on the block's system clock.

Two tick streams arrive from outside: a reference tick (nominally from a 24 MHz crystal) and a PLL tick. A bypass bit picks one of them. A second bit can thin the chosen stream to three quarters of its rate. The stream then feeds a CPU divider, a bus divider that counts CPU pulses, and a fixed halving stage that produces the peripheral enable. A separate low-frequency tick is passed through unchanged.

With the power-on control word and a PLL tick running at a given rate, the ratios are 1/4, 1/8 and 1/16 of that rate. For a 532 MHz PLL this gives 133, 66.5 and 33.25 MHz.

Top module: `clkctl_top`

## Requirements
- R1: The register window holds 28 fully writable 32-bit words at byte offsets 0x00 to 0x6C. The word index is the offset shifted right by two. A write with `regWe` high takes effect at the next clock edge. `regRdata` shows the addressed word combinationally.
- R2: At any offset of 0x70 or above, `regErr` is 1, `regRdata` is 0, and a write changes no word.
- R3: At an offset whose two low bits are not both zero, `regErr` is 1, `regRdata` is 0, and a write changes no word. `regErr` is 0 for every aligned offset below 0x70.
- R4: After reset all words are zero except these: word 0 = 0x800B2C01, word 1 = 0x84042800, word 2 = 0xD0030000, word 3 = 0x028A0100, word 4 = 0x04008100, word 5 = 0x00000438, words 6 to 9 = 0x01010101, word 23 = 0x00A00000, words 24 and 25 = 0x0000A030, and word 26 = 0x43000000.
- R5: In word 2, bit 22 = 1 selects `refTick` as the source stream and bit 22 = 0 selects `pllTick`.
- R6: A 2-bit counter advances on every source tick and is cleared by reset. When bit 14 of word 2 is 1, a source tick that arrives while the counter holds 3 is dropped. When bit 14 is 0, no tick is dropped.
- R7: `cpuEn` pulses, in the same cycle, on every (D+1)-th tick of the thinned stream, where D is bits 31:30 of word 2.
- R8: `busEn` pulses on every (B+1)-th `cpuEn` pulse, where B is bits 29:28 of word 2.
- R9: `perEn` pulses on every second `busEn` pulse, starting with the second one after reset.
- R10: When a write changes D or B, that divider restarts its count from the next input tick. Its first pulse after the change then comes on exactly the (new value + 1)-th tick. A write that leaves the field unchanged does not disturb the count.
- R11: `lowTickOut` equals `lowTickIn` in every cycle.
- R12: With the reset control word and `pllTick` held high, `cpuEn` pulses every 4th cycle, `busEn` every 8th and `perEn` every 16th.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regAddr | input | 8 | Byte offset of the access |
| regWe | input | 1 | Write enable |
| regWdata | input | 32 | Write data |
| regRdata | output | 32 | Read data for `regAddr` |
| regErr | output | 1 | Access is out of range or misaligned |
| refTick | input | 1 | Reference tick stream |
| pllTick | input | 1 | PLL tick stream |
| lowTickIn | input | 1 | Low-frequency tick input |
| cpuEn | output | 1 | CPU clock-enable pulse |
| busEn | output | 1 | Bus clock-enable pulse |
| perEn | output | 1 | Peripheral clock-enable pulse |
| lowTickOut | output | 1 | Low-frequency tick output |

## Verification
The hardest situation to reach is a divider field change that lands part way through a count. The restart must come at the right tick and must not add or lose a pulse, and that also has to hold when the 3/4 thinning is removing ticks at the same time. The stimulus produces this by rewriting the control word while random ticks are flowing on both sources. Some of those rewrites change the divide fields and some leave them unchanged. Every cycle is compared against a behavioural model that counts ticks.

// File: rtl/clkctl_pkg.sv
package clkctl_pkg;

  localparam int DATA_W     = 32;
  localparam int NUM_WORDS  = 28;
  localparam int CTRL_IDX   = 2;
  localparam int DIV_W      = 2;
  localparam int CPU_DIV_LSB = 30;
  localparam int BUS_DIV_LSB = 28;
  localparam int BYPASS_BIT  = 22;
  localparam int THIN_BIT    = 14;

  // strobes and settings handed from the register side to the divider chain
  typedef struct packed {
    logic             srcBypass;
    logic             cpuThin;
    logic [DIV_W-1:0] cpuDiv;
    logic [DIV_W-1:0] busDiv;
    logic             cpuRestart;
    logic             busRestart;
  } chainCtl_t;

  function automatic logic [DATA_W-1:0] resetWord(input int idx);
    logic [DATA_W-1:0] v;
    case (idx)
      0:       v = 32'h800B2C01;
      1:       v = 32'h84042800;
      2:       v = 32'hD0030000;
      3:       v = 32'h028A0100;
      4:       v = 32'h04008100;
      5:       v = 32'h00000438;
      6, 7, 8, 9: v = 32'h01010101;
      23:      v = 32'h00A00000;
      24, 25:  v = 32'h0000A030;
      26:      v = 32'h43000000;
      default: v = '0;
    endcase
    return v;
  endfunction

endpackage

// File: rtl/clkctl_regs.sv
module clkctl_regs
  import clkctl_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int WORDS  = NUM_WORDS
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWe,
  input  logic [DATA_W-1:0] regWdata,
  output logic [DATA_W-1:0] regRdata,
  output logic              regErr,
  output chainCtl_t         ctl
);

  localparam int IDX_W = $clog2(WORDS);
  localparam int LIMIT = WORDS * 4;

  logic [DATA_W-1:0] bank [WORDS];
  logic              inRange;
  logic              aligned;
  logic              hit;
  logic [IDX_W-1:0]  idx;
  logic              ctrlWrite;
  logic              cpuRestartQ;
  logic              busRestartQ;

  assign inRange = regAddr < ADDR_W'(LIMIT);
  assign aligned = regAddr[1:0] == 2'b00;
  assign hit     = inRange && aligned;
  assign idx     = regAddr[IDX_W+1:2];
  assign regErr  = !hit;

  always_comb begin
    regRdata = '0;
    if (hit) regRdata = bank[idx];
  end

  for (genvar w = 0; w < WORDS; w++) begin : g_word
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                                  bank[w] <= resetWord(w);
      else if (regWe && hit && idx == IDX_W'(w))  bank[w] <= regWdata;
    end
  end

  assign ctrlWrite = regWe && hit && idx == IDX_W'(CTRL_IDX);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cpuRestartQ <= 1'b0;
      busRestartQ <= 1'b0;
    end else begin
      cpuRestartQ <= ctrlWrite &&
        (regWdata[CPU_DIV_LSB +: DIV_W] != bank[CTRL_IDX][CPU_DIV_LSB +: DIV_W]);
      busRestartQ <= ctrlWrite &&
        (regWdata[BUS_DIV_LSB +: DIV_W] != bank[CTRL_IDX][BUS_DIV_LSB +: DIV_W]);
    end
  end

  always_comb begin
    ctl.srcBypass  = bank[CTRL_IDX][BYPASS_BIT];
    ctl.cpuThin    = bank[CTRL_IDX][THIN_BIT];
    ctl.cpuDiv     = bank[CTRL_IDX][CPU_DIV_LSB +: DIV_W];
    ctl.busDiv     = bank[CTRL_IDX][BUS_DIV_LSB +: DIV_W];
    ctl.cpuRestart = cpuRestartQ;
    ctl.busRestart = busRestartQ;
  end

endmodule

// File: rtl/clkctl_div.sv
module clkctl_div #(
  parameter int W = 2
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         inTick,
  input  logic         restart,
  input  logic [W-1:0] divVal,
  output logic         outTick
);

  logic [W-1:0] cnt;
  logic [W-1:0] effCnt;
  logic         atEnd;

  assign effCnt  = restart ? '0 : cnt;
  assign atEnd   = effCnt == divVal;
  assign outTick = inTick && atEnd;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)       cnt <= '0;
    else if (inTick) cnt <= atEnd ? '0 : effCnt + W'(1);
    else             cnt <= effCnt;
  end

endmodule

// File: rtl/clkctl_chain.sv
module clkctl_chain
  import clkctl_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  chainCtl_t ctl,
  input  logic      refTick,
  input  logic      pllTick,
  output logic      cpuEn,
  output logic      busEn,
  output logic      perEn
);

  logic       srcTick;
  logic [1:0] thinPhase;
  logic       thinTick;

  assign srcTick  = ctl.srcBypass ? refTick : pllTick;
  assign thinTick = srcTick && !(ctl.cpuThin && thinPhase == 2'd3);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)        thinPhase <= 2'd0;
    else if (srcTick) thinPhase <= thinPhase + 2'd1;
  end

  clkctl_div #(.W(DIV_W)) i_cpuDiv (
    .clk(clk), .rstN(rstN), .inTick(thinTick),
    .restart(ctl.cpuRestart), .divVal(ctl.cpuDiv), .outTick(cpuEn)
  );

  clkctl_div #(.W(DIV_W)) i_busDiv (
    .clk(clk), .rstN(rstN), .inTick(cpuEn),
    .restart(ctl.busRestart), .divVal(ctl.busDiv), .outTick(busEn)
  );

  clkctl_div #(.W(1)) i_perDiv (
    .clk(clk), .rstN(rstN), .inTick(busEn),
    .restart(1'b0), .divVal(1'b1), .outTick(perEn)
  );

endmodule

// File: rtl/clkctl_top.sv
module clkctl_top
  import clkctl_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWe,
  input  logic [DATA_W-1:0] regWdata,
  output logic [DATA_W-1:0] regRdata,
  output logic              regErr,
  input  logic              refTick,
  input  logic              pllTick,
  input  logic              lowTickIn,
  output logic              cpuEn,
  output logic              busEn,
  output logic              perEn,
  output logic              lowTickOut
);

  chainCtl_t ctl;

  clkctl_regs #(.ADDR_W(ADDR_W), .WORDS(NUM_WORDS)) i_regs (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWe(regWe),
    .regWdata(regWdata), .regRdata(regRdata), .regErr(regErr), .ctl(ctl)
  );

  clkctl_chain i_chain (
    .clk(clk), .rstN(rstN), .ctl(ctl), .refTick(refTick),
    .pllTick(pllTick), .cpuEn(cpuEn), .busEn(busEn), .perEn(perEn)
  );

  assign lowTickOut = lowTickIn;

endmodule

// File: rtl/clkctl_chk.sv
module clkctl_chk #(
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic [ADDR_W-1:0] regAddr,
  input logic [31:0]       regRdata,
  input logic              regErr,
  input logic              refTick,
  input logic              pllTick,
  input logic              cpuEn,
  input logic              busEn,
  input logic              perEn
);

  logic busParity;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)      busParity <= 1'b0;
    else if (busEn) busParity <= !busParity;
  end

  // R2 R3
  err_reads_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    regErr |-> regRdata == 32'd0);

  // R2
  high_offset_err_chk: assert property (@(posedge clk) disable iff (!rstN)
    (regAddr >= ADDR_W'(8'h70)) |-> regErr);

  // R7
  cpu_needs_tick_chk: assert property (@(posedge clk) disable iff (!rstN)
    cpuEn |-> (refTick || pllTick));

  // R8
  bus_needs_cpu_chk: assert property (@(posedge clk) disable iff (!rstN)
    busEn |-> cpuEn);

  // R9
  per_needs_bus_chk: assert property (@(posedge clk) disable iff (!rstN)
    perEn |-> busEn);

  // R9
  per_second_bus_chk: assert property (@(posedge clk) disable iff (!rstN)
    busEn |-> (perEn == busParity));

endmodule

bind clkctl_top clkctl_chk #(.ADDR_W(ADDR_W)) i_chk (
  .clk(clk), .rstN(rstN), .regAddr(regAddr), .regRdata(regRdata),
  .regErr(regErr), .refTick(refTick), .pllTick(pllTick),
  .cpuEn(cpuEn), .busEn(busEn), .perEn(perEn)
);

// File: tb/test_clkctl_top.sv
`timescale 1ns/1ps
module test_clkctl_top;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [7:0]  regAddr = '0;
  logic        regWe = 1'b0;
  logic [31:0] regWdata = '0;
  logic [31:0] regRdata;
  logic        regErr;
  logic        refTick = 1'b0;
  logic        pllTick = 1'b0;
  logic        lowTickIn = 1'b0;
  logic        cpuEn, busEn, perEn, lowTickOut;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;
  string tag = "R4";

  always #10 clk = !clk;

  clkctl_top i_clkctl_top (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWe(regWe),
    .regWdata(regWdata), .regRdata(regRdata), .regErr(regErr),
    .refTick(refTick), .pllTick(pllTick), .lowTickIn(lowTickIn),
    .cpuEn(cpuEn), .busEn(busEn), .perEn(perEn), .lowTickOut(lowTickOut)
  );

  // behavioural reference model
  logic [31:0] mReg [28];
  int q, cpuCnt, busCnt, perCnt, lastCpu, lastBus;

  function automatic logic [31:0] powerOn(int i);
    if (i == 0) return 32'h800B2C01;
    if (i == 1) return 32'h84042800;
    if (i == 2) return 32'hD0030000;
    if (i == 3) return 32'h028A0100;
    if (i == 4) return 32'h04008100;
    if (i == 5) return 32'h00000438;
    if (i >= 6 && i <= 9) return 32'h01010101;
    if (i == 23) return 32'h00A00000;
    if (i == 24 || i == 25) return 32'h0000A030;
    if (i == 26) return 32'h43000000;
    return 32'h0;
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h (t=%0t)", req, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < 28; i++) mReg[i] = powerOn(i);
      q = 0; cpuCnt = 0; busCnt = 0; perCnt = 0;
      lastCpu = 3; lastBus = 1;
    end else begin
      bit hit, src, pass, cOut, bOut, pOut;
      logic [31:0] ctrl, expR;
      int d, b;
      hit  = (regAddr < 8'h70) && (regAddr[1:0] == 2'b00);
      expR = hit ? mReg[regAddr >> 2] : 32'h0;
      check(regRdata === expR, tag, "regRdata", regRdata, expR);
      check(regErr === !hit, (regAddr >= 8'h70) ? "R2" : "R3", "regErr",
            {31'b0, regErr}, {31'b0, !hit});
      ctrl = mReg[2];
      d = int'(ctrl[31:30]);
      b = int'(ctrl[29:28]);
      src  = ctrl[22] ? refTick : pllTick;           // R5
      pass = src && !(ctrl[14] && q == 3);            // R6
      if (src) q = (q + 1) % 4;
      if (d != lastCpu) begin cpuCnt = 0; lastCpu = d; end  // R10
      cOut = pass && cpuCnt == d;                     // R7
      if (pass) cpuCnt = cOut ? 0 : cpuCnt + 1;
      if (b != lastBus) begin busCnt = 0; lastBus = b; end  // R10
      bOut = cOut && busCnt == b;                     // R8
      if (cOut) busCnt = bOut ? 0 : busCnt + 1;
      pOut = bOut && perCnt == 1;                     // R9
      if (bOut) perCnt = pOut ? 0 : 1;
      check(cpuEn === cOut, {tag, " R7"}, "cpuEn", {31'b0, cpuEn}, {31'b0, cOut});
      check(busEn === bOut, {tag, " R8"}, "busEn", {31'b0, busEn}, {31'b0, bOut});
      check(perEn === pOut, {tag, " R9"}, "perEn", {31'b0, perEn}, {31'b0, pOut});
      check(lowTickOut === lowTickIn, "R11", "lowTickOut",
            {31'b0, lowTickOut}, {31'b0, lowTickIn});
      if (regWe && hit) mReg[regAddr >> 2] = regWdata;
    end
  end

  task automatic wr(input logic [7:0] a, input logic [31:0] v);
    @(posedge clk); #1;
    regAddr = a; regWdata = v; regWe = 1'b1;
    @(posedge clk); #1;
    regWe = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a);
    @(posedge clk); #1;
    regAddr = a; regWe = 1'b0;
  endtask

  task automatic ticks(input int n, input int refPct, input int pllPct);
    repeat (n) begin
      @(posedge clk); #1;
      refTick   = ($urandom_range(99) < refPct);
      pllTick   = ($urandom_range(99) < pllPct);
      lowTickIn = $urandom_range(1);
    end
  endtask

  initial begin
    #(20 * 200000);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;

    tag = "R4";
    for (int i = 0; i < 28; i++) rd(8'(i * 4));

    tag = "R12";
    rd(8'h08);
    ticks(200, 0, 100);

    tag = "R1";
    for (int i = 0; i < 28; i++)
      if (i != 2) wr(8'(i * 4), 32'hA5000000 ^ (32'(i) * 32'h01030507));
    for (int i = 0; i < 28; i++) rd(8'(i * 4));

    tag = "R2";
    wr(8'h70, 32'hDEADBEEF); rd(8'h70);
    wr(8'hFC, 32'h12345678); rd(8'hFC);
    for (int i = 0; i < 28; i++) rd(8'(i * 4));

    tag = "R3";
    wr(8'h09, 32'hFFFFFFFF); rd(8'h09);
    wr(8'h02, 32'hFFFFFFFF); rd(8'h03);
    rd(8'h08); rd(8'h00);

    tag = "R5";
    wr(8'h08, 32'h10400000);
    ticks(300, 70, 30);
    wr(8'h08, 32'h10000000);
    ticks(300, 70, 30);

    tag = "R6";
    wr(8'h08, 32'h00004000);
    ticks(300, 0, 80);
    wr(8'h08, 32'h00404000);
    ticks(300, 90, 10);

    tag = "R10";
    for (int k = 0; k < 60; k++) begin
      logic [31:0] v;
      v = {$urandom_range(3) == 0 ? 2'b00 : 2'($urandom_range(3)),
           2'($urandom_range(3)), 7'b0, 1'($urandom_range(1)), 7'b0,
           1'($urandom_range(1)), 14'b0};
      wr(8'h08, v);
      ticks($urandom_range(3, 40), 60, 70);
      if (k % 5 == 0) begin
        wr(8'h08, v);
        ticks(10, 60, 70);
      end
    end

    tag = "R12";
    wr(8'h08, 32'hD0030000);
    ticks(400, 0, 100);

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule